// File: doc/BRIEF.md
# Taken-Branch Target Buffer

This block is a small, fully associative cache of branch targets used at instruction fetch. Each entry holds the complete address of a branch that was seen to be taken, together with the address fetch should go to next. Every cycle the fetch address is compared against all valid entries at once. On a match the stored target is presented as the next fetch address. Otherwise the next fetch address is the sequential one, fetch address plus four.

Later in the pipeline, each executed branch is reported on a resolve port. The report carries the branch address, whether fetch found it in the buffer, whether it was actually taken, and its real target. The buffer uses these reports to fill, correct and prune itself.

- A taken branch that is not yet stored is inserted.
- A stored branch whose target has changed is rewritten where it sits.
- A branch that fetch found in the buffer but that turned out not taken is removed.

The resolve port is a valid-qualified stream with no ready signal. The block never applies back-pressure: it acts on a report in the same cycle that the valid bit is high. The fetch lookup is purely combinational.

Top module: `tbtb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup hits only when a valid entry's stored address equals the fetch address in every bit. On a hit, `pred_hit` is 1 and `pred_next_pc` is that entry's stored target.
- R3: On a miss, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, wrapping modulo 2^32.
- R4: A report with `rs_valid=1` and `rs_taken=1`, whose address is held by no valid entry, inserts that address and target into the lowest-numbered invalid entry. This happens whatever the value of `rs_was_hit`.
- R5: A report with `rs_valid=1` and `rs_taken=1`, whose address is already held, overwrites that entry's target in place. No second entry for the address is created.
- R6: A report with `rs_valid=1`, `rs_taken=0` and `rs_was_hit=1` invalidates the entry holding that address.
- R7: A report with `rs_taken=0` and `rs_was_hit=0` changes nothing. A cycle with `rs_valid=0` also changes nothing.
- R8: When an insertion finds all 16 entries valid, it replaces the entry named by a replacement pointer, then advances the pointer by one, wrapping from 15 to 0. The pointer is 0 after reset and moves only on such replacements.
- R9: Resolve updates become visible to lookups from the next cycle. A lookup in the same cycle as a report sees the earlier contents.
- R10: Addresses differing only in bit 31 are distinct entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address found in buffer |
| pred_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Resolve report present this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_was_hit | input | 1 | The branch hit in the buffer when fetched |
| rs_taken | input | 1 | The branch was actually taken |
| rs_target | input | 32 | Actual target of the branch |

## Verification
The bench fills the buffer past capacity, so that both replacement order and the preference for freed slots show in later lookups. A pointer that advanced on every insertion, or that ignored freed slots, would evict the wrong branches. It inserts a second report for an address already present. A design that allocated blindly would leave two matching entries and could return a stale target. It also pairs addresses that differ only in the top bit, which catches a partial tag compare. Finally, it issues not-taken reports with the hit flag both set and clear, and lookups in the same cycle as a report. These catch deletion keyed on the wrong condition and updates that bypass into the same-cycle lookup.

// File: rtl/tbtb_pkg.sv
package tbtb_pkg;
  localparam int unsigned TBTB_PC_W    = 32;
  localparam int unsigned TBTB_ENTRIES = 16;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_FIX   = 2'd1,
    ACT_FILL  = 2'd2,
    ACT_DROP  = 2'd3
  } tbtb_act_e;
endpackage

// File: rtl/tbtb_cam.sv
module tbtb_cam #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0] vld,
  input  logic [W-1:0] tags [N],
  input  logic [W-1:0] key,
  output logic [N-1:0] match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tbtb_victim.sv
module tbtb_victim #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          advance,
  output logic [IW-1:0] slot,
  output logic          full
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign full = &vld;
  assign slot = full ? ptr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R8: the pointer holds unless a replacement used it
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));
  // R8: a replacement moves the pointer by exactly one, wrapping
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr_q == (($past(ptr_q) == IW'(N - 1)) ? '0 : $past(ptr_q) + 1'b1)));
  // R4: a free entry is chosen whenever one exists
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !vld[slot]);
endmodule

// File: rtl/tbtb_top.sv
module tbtb_top
  import tbtb_pkg::*;
#(
  parameter int unsigned PC_W    = TBTB_PC_W,
  parameter int unsigned ENTRIES = TBTB_ENTRIES,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_was_hit,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [ENTRIES-1:0] f_match;
  logic [ENTRIES-1:0] r_match;
  logic [PC_W-1:0]    f_tgt;
  logic [IW-1:0]      fill_slot;
  logic               all_used;
  logic               rr_advance;
  tbtb_act_e          act;

  // fetch side lookup
  tbtb_cam #(.N(ENTRIES), .W(PC_W)) u_fetch_cam (
    .vld(vld_q), .tags(tag_q), .key(fetch_pc), .match(f_match)
  );

  always_comb begin
    f_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (f_match[i]) f_tgt = f_tgt | tgt_q[i];
    end
  end

  assign pred_hit     = |f_match;
  assign pred_next_pc = pred_hit ? f_tgt : fetch_pc + PC_W'(PC_STEP);

  // resolve side lookup
  tbtb_cam #(.N(ENTRIES), .W(PC_W)) u_rsv_cam (
    .vld(vld_q), .tags(tag_q), .key(rs_pc), .match(r_match)
  );

  always_comb begin
    act = ACT_IDLE;
    if (rs_valid) begin
      if (rs_taken)                    act = (|r_match) ? ACT_FIX : ACT_FILL;
      else if (rs_was_hit && |r_match) act = ACT_DROP;
    end
  end

  assign rr_advance = (act == ACT_FILL) && all_used;

  tbtb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .advance(rr_advance),
    .slot(fill_slot), .full(all_used)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      case (act)
        ACT_FIX: begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (r_match[i]) tgt_q[i] <= rs_target;
          end
        end
        ACT_FILL: begin
          vld_q[fill_slot] <= 1'b1;
          tag_q[fill_slot] <= rs_pc;
          tgt_q[fill_slot] <= rs_target;
        end
        ACT_DROP: begin
          vld_q <= vld_q & ~r_match;
        end
        default: ;
      endcase
    end
  end

  // checking state: last report and whether it is now stored
  logic [PC_W-1:0] chk_pc_q;
  logic [PC_W-1:0] chk_tgt_q;
  logic            chk_hit;
  logic [PC_W-1:0] chk_tgt;

  always_ff @(posedge clk) begin
    chk_pc_q  <= rs_pc;
    chk_tgt_q <= rs_target;
  end

  always_comb begin
    chk_hit = 1'b0;
    chk_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && tag_q[i] == chk_pc_q) begin
        chk_hit = 1'b1;
        chk_tgt = tgt_q[i];
      end
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vld_q == '0));
  a_r5_unique_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_match));
  a_r5_unique_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(r_match));
  a_r4_taken_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=> (chk_hit && chk_tgt == chk_tgt_q));
  a_r6_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && rs_was_hit) |=> !chk_hit);
  a_r7_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_valid || (!rs_taken && !rs_was_hit)) |=> $stable(vld_q));
endmodule

// File: tb/tb_tbtb_top.sv
`timescale 1ns/1ps
module tb_tbtb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_was_hit = 1'b0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tbtb_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_next_pc(pred_next_pc), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_was_hit(rs_was_hit), .rs_taken(rs_taken), .rs_target(rs_target)
  );

  // behavioural model
  bit          m_vld [N];
  logic [31:0] m_pc  [N];
  logic [31:0] m_tgt [N];
  int          m_ptr;
  logic [31:0] pool [24];

  function automatic int m_find(input logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_pc[i] == pc) return i;
    return -1;
  endfunction

  task automatic m_update(input bit v, input logic [31:0] pc, input bit hit,
                          input bit tk, input logic [31:0] tgt);
    int j;
    int fr;
    if (!v) return;
    j = m_find(pc);
    if (tk) begin
      if (j >= 0) m_tgt[j] = tgt;
      else begin
        fr = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) fr = i;
        if (fr < 0) begin
          fr = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_vld[fr] = 1'b1;
        m_pc[fr]  = pc;
        m_tgt[fr] = tgt;
      end
    end else if (hit && j >= 0) begin
      m_vld[j] = 1'b0;
    end
  endtask

  task automatic step(input logic [31:0] fpc, input bit v, input logic [31:0] pc,
                      input bit hit, input bit tk, input logic [31:0] tgt,
                      input string req);
    int j;
    bit exp_hit;
    logic [31:0] exp_nx;
    @(negedge clk);
    fetch_pc = fpc; rs_valid = v; rs_pc = pc; rs_was_hit = hit;
    rs_taken = tk; rs_target = tgt;
    #1;
    j = m_find(fpc);
    exp_hit = (j >= 0);
    exp_nx  = exp_hit ? m_tgt[j] : fpc + 32'd4;
    total++;
    if (pred_hit !== exp_hit || pred_next_pc !== exp_nx) begin
      bad++;
      $display("FAIL %s pc=%h actual hit=%0b next=%h expected hit=%0b next=%h",
               req, fpc, pred_hit, pred_next_pc, exp_hit, exp_nx);
    end
    @(posedge clk);
    m_update(v, pc, hit, tk, tgt);
  endtask

  task automatic look(input logic [31:0] fpc, input string req);
    step(fpc, 1'b0, '0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 24; k++) begin
      look(pool[k], req);
      look(pool[k] ^ 32'h8000_0000, "R10");
    end
  endtask

  function automatic logic [31:0] tg(input logic [31:0] pc, input int salt);
    return (pc * 3) + 32'h100 + salt * 32'h40;
  endfunction

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 24; k++) pool[k] = 32'h0000_1000 + k * 32'h24;
    pool[23] = 32'hFFFF_FFFC; // wraps on +4
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: empty buffer, sequential next address, wrap included
    sweep("R1");
    look(32'hFFFF_FFFC, "R3");

    // R4 / R2: insert four taken branches, then look them up
    for (int k = 0; k < 4; k++) step(pool[10], 1'b1, pool[k], 1'b0, 1'b1, tg(pool[k], 0), "R4");
    for (int k = 0; k < 4; k++) look(pool[k], "R2");

    // R10: top-bit alias is separate
    look(pool[0] ^ 32'h8000_0000, "R10");
    step(pool[0], 1'b1, pool[0] ^ 32'h8000_0000, 1'b0, 1'b1, 32'hABCD_0000, "R10");
    look(pool[0] ^ 32'h8000_0000, "R10");
    look(pool[0], "R10");

    // R5: target changes in place, repeated miss report does not duplicate
    step(pool[1], 1'b1, pool[1], 1'b1, 1'b1, 32'h5555_0000, "R5");
    look(pool[1], "R5");
    step(pool[2], 1'b1, pool[2], 1'b0, 1'b1, 32'h6666_0000, "R5");
    look(pool[2], "R5");
    step(pool[2], 1'b1, pool[2], 1'b1, 1'b0, '0, "R5");
    look(pool[2], "R5");

    // R6: hit branch resolved not taken is removed
    step(pool[3], 1'b1, pool[3], 1'b1, 1'b0, '0, "R6");
    look(pool[3], "R6");

    // R7: not-taken without hit flag and idle cycles change nothing
    step(pool[0], 1'b1, pool[0], 1'b0, 1'b0, '0, "R7");
    look(pool[0], "R7");
    step(pool[1], 1'b0, pool[1], 1'b1, 1'b0, '0, "R7");
    look(pool[1], "R7");

    // R9: same-cycle lookup sees old contents
    step(pool[4], 1'b1, pool[4], 1'b0, 1'b1, tg(pool[4], 1), "R9");
    look(pool[4], "R9");

    // R8: overfill to force round-robin replacement
    for (int k = 5; k < 23; k++) step(pool[k], 1'b1, pool[k], 1'b0, 1'b1, tg(pool[k], 2), "R8");
    sweep("R8");

    // R4: a freed slot is preferred over the pointer
    step(pool[9], 1'b1, pool[9], 1'b1, 1'b0, '0, "R6");
    step(pool[0], 1'b1, pool[0], 1'b0, 1'b1, tg(pool[0], 3), "R4");
    step(pool[1], 1'b1, pool[1], 1'b0, 1'b1, tg(pool[1], 3), "R8");
    sweep("R4");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int a, b, h;
      logic [31:0] pc;
      a = $urandom_range(0, 23);
      b = $urandom_range(0, 23);
      pc = pool[b] ^ (($urandom_range(0, 7) == 0) ? 32'h8000_0000 : 32'h0);
      h = (m_find(pc) >= 0) ? 1 : 0;
      if ($urandom_range(0, 9) == 0) h = $urandom_range(0, 1);
      step(pool[a], $urandom_range(0, 3) != 0, pc, h[0],
           $urandom_range(0, 2) != 0, tg(pc, $urandom_range(0, 5)), "R2");
    end
    sweep("R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule